// File: doc/BRIEF.md
# Fixed-point adder-subtractor with format alignment

This block adds or subtracts two fixed-point operands whose formats need not match. Each operand format is set at elaboration by three values: whether it is signed, its total bit count (word length) and how many of those bits sit above the binary point (integer length). Integer length may exceed the word length or be negative. The operation, add or subtract, is also fixed at elaboration.

Both operands are moved onto one common grid. The result format then grows by fixed rules, so the answer is always exact and can never wrap. The result leaves through a register one cycle after a valid input. Its format is presented beside it on constant outputs, so a later stage can requantize without having to recompute the growth rules.

Top module: `fxp_addsub`

## Requirements
- R1: An operand holds an integer mantissa times 2^-(word length − integer length). In a signed operand the most significant bit is the sign bit and the mantissa is two's complement. In an unsigned operand the mantissa is plain binary.
- R2: Before the operation, both operands are aligned to a common grid. Its integer length is the larger of the two integer lengths, and its fractional length is the larger of the two fractional lengths. Signed operands are sign-extended on the left, unsigned operands are zero-extended on the left, and new low-order fractional bits are filled with zeros.
- R3: Adding two unsigned operands gives an unsigned result whose word length and integer length are each one greater than those of the common grid.
- R4: When exactly one operand is signed, the result is signed and receives one further bit in both word length and integer length, beyond the growth of R3.
- R5: Subtraction grows like addition but always yields a signed result, even when both inputs are unsigned.
- R6: Until the cap of R7 applies, the result equals the exact sum or difference of the two operand values, for every input pair.
- R7: The result word length never exceeds 64. When the raw width would be larger, the integer length is kept and the lowest fractional bits are discarded, which rounds toward minus infinity.
- R8: out_valid equals in_valid delayed by one clock. When in_valid is high, out_data shows that pair's result on the next cycle.
- R9: In a cycle where in_valid is low, out_data keeps its previous value on the next cycle.
- R10: While rst_n is low, out_valid and out_data are zero.
- R11: out_signed, out_wl and out_iwl are constant. They equal the derived result format: the sign flag, the word length, and the integer length as a signed 16-bit number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| a_data | input | A_WL | First operand (minuend when subtracting) |
| b_data | input | B_WL | Second operand (subtrahend when subtracting) |
| out_valid | output | 1 | Result valid |
| out_data | output | RES_WL | Registered result in the derived format |
| out_signed | output | 1 | Result format is signed |
| out_wl | output | 7 | Result word length |
| out_iwl | output | 16 | Result integer length, two's complement |

## Verification
Four instances run side by side with different formats, all driven by the same stream:
- A signed and an unsigned operand with different fractional lengths, which separates correct sign extension from zero extension and checks that the right side is zero-filled.
- Two unsigned operands of identical format, which confirms that plain addition keeps the result unsigned.
- An unsigned subtraction, which shows whether the result turns signed.
- A wide signed pair whose raw width exceeds 64, which exercises the truncation of low-order bits.

The stream contains zeros, all-ones words, the largest positive and most negative codes, and pseudo-random words. It also includes idle gaps, which separate a correctly held output from one that changes while no input is valid.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

  function automatic int fxp_max(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // bits right of the binary point; negative when the LSB weight exceeds 1
  function automatic int fxp_frac(input int wl, input int iwl);
    return wl - iwl;
  endfunction

  function automatic bit fxp_res_signed(input bit sa, input bit sb, input bit sub);
    return sa | sb | sub;
  endfunction

  function automatic int fxp_res_iwl(input int ia, input int ib, input bit sa, input bit sb);
    return fxp_max(ia, ib) + 1 + ((sa != sb) ? 1 : 0);
  endfunction

  function automatic int fxp_cap(input int raw_wl);
    return (raw_wl > 64) ? 64 : raw_wl;
  endfunction

endpackage

// File: rtl/fxp_align.sv
module fxp_align #(
  parameter int IN_WL     = 8,
  parameter bit IN_SIGNED = 1'b1,
  parameter int SHIFT     = 0,
  parameter int OUT_WL    = 16
) (
  input  logic [IN_WL-1:0]  din,
  output logic [OUT_WL-1:0] dout
);
  localparam int PAD = OUT_WL - IN_WL;

  logic [OUT_WL-1:0] ext;

  generate
    if (IN_SIGNED) begin : g_sext
      assign ext = {{PAD{din[IN_WL-1]}}, din};
    end else begin : g_zext
      assign ext = {{PAD{1'b0}}, din};
    end
  endgenerate

  // zero-fill on the right moves the binary point onto the common grid
  assign dout = ext << SHIFT;
endmodule

// File: rtl/fxp_addsub_core.sv
module fxp_addsub_core #(
  parameter int W   = 16,
  parameter bit SUB = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  generate
    if (SUB) begin : g_sub
      assign y = a - b;
    end else begin : g_add
      assign y = a + b;
    end
  endgenerate
endmodule

// File: rtl/fxp_addsub.sv
module fxp_addsub
  import fxp_pkg::*;
#(
  parameter bit A_SIGNED = 1'b1,
  parameter int A_WL     = 8,
  parameter int A_IWL    = 4,
  parameter bit B_SIGNED = 1'b0,
  parameter int B_WL     = 10,
  parameter int B_IWL    = 3,
  parameter bit SUB      = 1'b0,
  localparam int RES_WL  = fxp_cap(fxp_res_iwl(A_IWL, B_IWL, A_SIGNED, B_SIGNED)
                                   + fxp_max(fxp_frac(A_WL, A_IWL), fxp_frac(B_WL, B_IWL)))
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [A_WL-1:0]          a_data,
  input  logic [B_WL-1:0]          b_data,
  output logic                     out_valid,
  output logic [RES_WL-1:0]        out_data,
  output logic                     out_signed,
  output logic [6:0]               out_wl,
  output logic signed [15:0]       out_iwl
);
  localparam int FA         = fxp_frac(A_WL, A_IWL);
  localparam int FB         = fxp_frac(B_WL, B_IWL);
  localparam int FL_C       = fxp_max(FA, FB);
  localparam int SHIFT_A    = FL_C - FA;
  localparam int SHIFT_B    = FL_C - FB;
  localparam bit RES_SIGNED = fxp_res_signed(A_SIGNED, B_SIGNED, SUB);
  localparam int RES_IWL    = fxp_res_iwl(A_IWL, B_IWL, A_SIGNED, B_SIGNED);
  localparam int RAW_WL     = RES_IWL + FL_C;

  // internal events, visible to the bound checker
  logic [RAW_WL-1:0] aligned_a;
  logic [RAW_WL-1:0] aligned_b;
  logic [RAW_WL-1:0] raw_sum;
  logic [RES_WL-1:0] res_next;

  fxp_align #(.IN_WL(A_WL), .IN_SIGNED(A_SIGNED), .SHIFT(SHIFT_A), .OUT_WL(RAW_WL))
    u_align_a (.din(a_data), .dout(aligned_a));

  fxp_align #(.IN_WL(B_WL), .IN_SIGNED(B_SIGNED), .SHIFT(SHIFT_B), .OUT_WL(RAW_WL))
    u_align_b (.din(b_data), .dout(aligned_b));

  fxp_addsub_core #(.W(RAW_WL), .SUB(SUB))
    u_core (.a(aligned_a), .b(aligned_b), .y(raw_sum));

  // keep the integer part; surplus width past 64 leaves from the bottom
  assign res_next = raw_sum[RAW_WL-1 -: RES_WL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res_next;
    end
  end

  assign out_signed = RES_SIGNED;
  assign out_wl     = 7'(RES_WL);
  assign out_iwl    = 16'(RES_IWL);
endmodule

// File: rtl/fxp_addsub_chk.sv
module fxp_addsub_chk #(
  parameter int A_WL       = 8,
  parameter bit A_SIGNED   = 1'b1,
  parameter int B_WL       = 8,
  parameter bit B_SIGNED   = 1'b1,
  parameter int RAW_WL     = 16,
  parameter int RES_WL     = 16,
  parameter int SHIFT_A    = 0,
  parameter int SHIFT_B    = 0,
  parameter bit RES_SIGNED = 1'b1,
  parameter bit SUB        = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [A_WL-1:0]   a_data,
  input logic [B_WL-1:0]   b_data,
  input logic [RAW_WL-1:0] aligned_a,
  input logic [RAW_WL-1:0] aligned_b,
  input logic [RAW_WL-1:0] raw_sum,
  input logic              out_valid,
  input logic [RES_WL-1:0] out_data
);
  logic [RAW_WL:0] wide_a, wide_b, wide_r;
  logic            fits;

  always_comb begin
    if (RES_SIGNED) begin
      wide_a = {aligned_a[RAW_WL-1], aligned_a};
      wide_b = {aligned_b[RAW_WL-1], aligned_b};
    end else begin
      wide_a = {1'b0, aligned_a};
      wide_b = {1'b0, aligned_b};
    end
    wide_r = SUB ? (wide_a - wide_b) : (wide_a + wide_b);
    fits   = RES_SIGNED ? (wide_r[RAW_WL] == wide_r[RAW_WL-1]) : !wide_r[RAW_WL];
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_data == $past(raw_sum[RAW_WL-1 -: RES_WL]));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> fits);

  generate
    if (A_SIGNED) begin : g_a_s
      // R2
      a_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_a[RAW_WL-1] == a_data[A_WL-1]);
    end else begin : g_a_u
      // R2
      a_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_a[RAW_WL-1] == 1'b0);
    end
    if (B_SIGNED) begin : g_b_s
      // R2
      b_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_b[RAW_WL-1] == b_data[B_WL-1]);
    end else begin : g_b_u
      // R2
      b_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_b[RAW_WL-1] == 1'b0);
    end
    if (SHIFT_A > 0) begin : g_a_fill
      // R2
      a_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_a[SHIFT_A-1:0] == '0);
    end
    if (SHIFT_B > 0) begin : g_b_fill
      // R2
      b_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aligned_b[SHIFT_B-1:0] == '0);
    end
  endgenerate
endmodule

bind fxp_addsub fxp_addsub_chk #(
  .A_WL(A_WL), .A_SIGNED(A_SIGNED), .B_WL(B_WL), .B_SIGNED(B_SIGNED),
  .RAW_WL(RAW_WL), .RES_WL(RES_WL), .SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B),
  .RES_SIGNED(RES_SIGNED), .SUB(SUB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_data(a_data), .b_data(b_data),
  .aligned_a(aligned_a), .aligned_b(aligned_b), .raw_sum(raw_sum),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/tb_fxp_addsub.sv
`timescale 1ns/1ps
module tb_fxp_addsub;
  // four formats: mixed-sign add, unsigned add, unsigned subtract, capped wide add
  localparam bit AS[4] = '{1'b1, 1'b0, 1'b0, 1'b1};
  localparam int AW[4] = '{8, 8, 8, 40};
  localparam int AI[4] = '{4, 6, 6, 8};
  localparam bit BS[4] = '{1'b0, 1'b0, 1'b0, 1'b1};
  localparam int BW[4] = '{10, 8, 6, 40};
  localparam int BI[4] = '{3, 6, 4, 38};
  localparam bit SB[4] = '{1'b0, 1'b0, 1'b1, 1'b0};
  // result formats worked out by hand from R3, R4, R5, R7
  localparam int EWL[4]  = '{13, 9, 9, 64};
  localparam int EIWL[4] = '{6, 7, 7, 39};
  localparam bit ESG[4]  = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam string TAG[4] = '{"R1 R2 R4 R6", "R1 R3 R6", "R1 R2 R5 R6", "R1 R2 R7"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] a_w = '0, b_w = '0;
  always #4 clk = ~clk;

  logic        ov[4];
  logic [63:0] od[4];
  logic        osg[4];
  logic [6:0]  owl[4];
  logic signed [15:0] oiwl[4];
  logic [12:0] d0; logic [8:0] d1; logic [8:0] d2; logic [63:0] d3;

  fxp_addsub #(.A_SIGNED(AS[0]), .A_WL(AW[0]), .A_IWL(AI[0]), .B_SIGNED(BS[0]), .B_WL(BW[0]),
               .B_IWL(BI[0]), .SUB(SB[0])) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_data(a_w[7:0]), .b_data(b_w[9:0]),
    .out_valid(ov[0]), .out_data(d0), .out_signed(osg[0]), .out_wl(owl[0]), .out_iwl(oiwl[0]));
  fxp_addsub #(.A_SIGNED(AS[1]), .A_WL(AW[1]), .A_IWL(AI[1]), .B_SIGNED(BS[1]), .B_WL(BW[1]),
               .B_IWL(BI[1]), .SUB(SB[1])) dut_uadd (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_data(a_w[7:0]), .b_data(b_w[7:0]),
    .out_valid(ov[1]), .out_data(d1), .out_signed(osg[1]), .out_wl(owl[1]), .out_iwl(oiwl[1]));
  fxp_addsub #(.A_SIGNED(AS[2]), .A_WL(AW[2]), .A_IWL(AI[2]), .B_SIGNED(BS[2]), .B_WL(BW[2]),
               .B_IWL(BI[2]), .SUB(SB[2])) dut_usub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_data(a_w[7:0]), .b_data(b_w[5:0]),
    .out_valid(ov[2]), .out_data(d2), .out_signed(osg[2]), .out_wl(owl[2]), .out_iwl(oiwl[2]));
  fxp_addsub #(.A_SIGNED(AS[3]), .A_WL(AW[3]), .A_IWL(AI[3]), .B_SIGNED(BS[3]), .B_WL(BW[3]),
               .B_IWL(BI[3]), .SUB(SB[3])) dut_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_data(a_w[39:0]), .b_data(b_w[39:0]),
    .out_valid(ov[3]), .out_data(d3), .out_signed(osg[3]), .out_wl(owl[3]), .out_iwl(oiwl[3]));

  assign od[0] = 64'(d0);
  assign od[1] = 64'(d1);
  assign od[2] = 64'(d2);
  assign od[3] = d3;

  int total = 0, bad = 0;
  logic [3:0][63:0] expq[$];
  logic [63:0] last[4];

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // reference: exact value as integer mantissas on the finest grid, then cap
  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b, input int i);
    logic signed [127:0] ma, mb, r;
    int fa, fb, flc, iwl, raw, res;
    logic [63:0] m;
    fa  = AW[i] - AI[i];
    fb  = BW[i] - BI[i];
    flc = (fa > fb) ? fa : fb;
    iwl = ((AI[i] > BI[i]) ? AI[i] : BI[i]) + 1 + ((AS[i] != BS[i]) ? 1 : 0);
    raw = iwl + flc;
    res = (raw > 64) ? 64 : raw;
    ma = '0; mb = '0;
    for (int k = 0; k < AW[i]; k++) ma[k] = a[k];
    for (int k = 0; k < BW[i]; k++) mb[k] = b[k];
    if (AS[i] && a[AW[i]-1]) ma = ma - (128'sd1 <<< AW[i]);
    if (BS[i] && b[BW[i]-1]) mb = mb - (128'sd1 <<< BW[i]);
    ma = ma <<< (flc - fa);
    mb = mb <<< (flc - fb);
    r  = SB[i] ? (ma - mb) : (ma + mb);
    r  = r >>> (raw - res);
    m  = '0;
    for (int k = 0; k < res; k++) m[k] = r[k];
    return m;
  endfunction

  task automatic send(input logic [63:0] a, input logic [63:0] b);
    logic [3:0][63:0] e;
    @(negedge clk);
    in_valid = 1'b1; a_w = a; b_w = b;
    for (int i = 0; i < 4; i++) e[i] = model(a, b, i);
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; a_w = ~a_w; b_w = b_w ^ 64'h5A5A_5A5A_5A5A_5A5A;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (ov[0]) begin
        logic [3:0][63:0] e;
        if (expq.size() == 0) check("R8 unexpected out_valid", 64'd1, 64'd0);
        else begin
          e = expq.pop_front();
          for (int i = 0; i < 4; i++) begin
            check(TAG[i], od[i], e[i]);
            check("R8 valid alignment", 64'(ov[i]), 64'd1);
            last[i] = od[i];
          end
        end
      end else begin
        for (int i = 0; i < 4; i++) begin
          check("R9 hold when idle", od[i], last[i]);
          check("R8 valid low", 64'(ov[i]), 64'd0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] lfsr_a, lfsr_b;
    for (int i = 0; i < 4; i++) last[i] = '0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      // R10 reset state
      check("R10 out_valid in reset", 64'(ov[i]), 64'd0);
      check("R10 out_data in reset", od[i], 64'd0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      // R11 constant format outputs; per-instance growth R3 R4 R5 R7
      check({"R11 signed ", TAG[i]}, 64'(osg[i]), 64'(ESG[i]));
      check({"R11 wl R3 R4 R5 R7 ", TAG[i]}, 64'(owl[i]), 64'(EWL[i]));
      check({"R11 iwl ", TAG[i]}, 64'(oiwl[i]), 64'(16'(EIWL[i])));
    end
    idle(2);
    send(64'h0, 64'h0);
    send('1, '1);
    send(64'h0000_007F_FFFF_FF7F, 64'h0000_007F_FFFF_FFFF);
    send(64'h0000_0080_0000_0080, 64'h0);
    send(64'h0, '1);
    send(64'h0000_0080_0000_0080, 64'h0000_0080_0000_0200);
    idle(3);
    send(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001);
    idle(1);
    lfsr_a = 64'h1234_5678_9ABC_DEF1;
    lfsr_b = 64'h0F1E_2D3C_4B5A_6978;
    for (int n = 0; n < 60; n++) begin
      lfsr_a = lfsr_a ^ (lfsr_a << 13); lfsr_a = lfsr_a ^ (lfsr_a >> 7); lfsr_a = lfsr_a ^ (lfsr_a << 17);
      lfsr_b = lfsr_b ^ (lfsr_b << 13); lfsr_b = lfsr_b ^ (lfsr_b >> 7); lfsr_b = lfsr_b ^ (lfsr_b << 17);
      send(lfsr_a, lfsr_b);
      if (lfsr_a[3:0] == 4'h0) idle(2);
    end
    idle(4);
    check("R8 all results drained", 64'(expq.size()), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule